// File: doc/BRIEF.md
# Cascaded Board Interrupt Controller

This block gathers sixteen board-level interrupt request lines and folds them onto four interrupt inputs of a host processor. Each request line is first passed through a two-stage synchronizer. A detector then turns it into a set pulse. Lines 1 to 14 are active-low level requests. Line 15 is a push-button style request that latches only on a falling edge. Line 0 is not connected to anything. Each set pulse latches a bit in a pending-flag register. A mask register, where a 1 disables a source, gates those flags before they are routed.

Each of the four output lines serves its own fixed, irregular subset of the sources. An output is raised when any flag in its subset is pending and unmasked. The outputs are not exclusive, so several may be high at once. Software finds out which source fired by reading both registers and scanning the result itself. It acknowledges a source by writing a word to the flag register in which that source's bit is 0.

Top module: `board_irq_cascade`

## Requirements
- R1: After reset the mask register reads 0xFFFF, the flag register reads 0x0000 and all four outputs are low.
- R2: The mask register is at byte offset 0x4. A write there stores all 16 data bits, bit 0 included, and a read there returns the stored word. A mask bit of 1 disables its source for routing.
- R3: Sources 1 to 14 are active-low level requests. A source driven low sets its flag from the third rising clock edge after the change. While the source stays low, its flag stays set, even if software writes a 0 to it.
- R4: The flag register is at byte offset 0xC. Writing a word clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. This holds as long as the source is not requesting in that cycle.
- R5: Source 15 sets its flag only on a high-to-low transition. If it is held low after its flag is cleared, or if it rises, the flag stays clear.
- R6: Flag bit 0 always reads 0, whatever source 0 does.
- R7: Output k is high one clock after (flags AND NOT mask AND G_k) becomes non-zero, and low one clock after it becomes zero. G_0=0x0028, G_1=0x0050, G_2=0x1C00, G_3=0x6386. Output bit k is port bit k.
- R8: Flags latch whatever the mask holds. Changing the mask leaves the flag register unchanged.
- R9: A read with rd_en low, or a read of any offset other than 0x4 or 0xC, returns 0. A write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_n_i | input | 16 | Board interrupt request lines, asynchronous, active low |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| cpu_irq_o | output | 4 | Interrupt lines to the host, active high, registered |

## Verification
A wrong flag bit shows up on the next read of offset 0xC. One clock later it also shows up on each output whose group contains that bit. A corrupted mask bit shows up only on the outputs, again one clock after the fault, and on a read of offset 0x4. A broken edge detector for source 15 is caught only when the button is held low across an acknowledge. It shows as a flag that comes back after being cleared.

// File: rtl/birq_pkg.sv
package birq_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_FLAG = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/birq_sync.sv
module birq_sync #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] async_i,
    output logic [N_SRC-1:0] sync_o
);

    logic [N_SRC-1:0] stage1_q;
    logic [N_SRC-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/birq_detect.sv
module birq_detect #(
    parameter int               N_SRC    = 16,
    parameter logic [N_SRC-1:0] USED_SRC = 16'hFFFE,
    parameter logic [N_SRC-1:0] EDGE_SRC = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_i,
    output logic [N_SRC-1:0] set_o
);

    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= sync_i;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (!USED_SRC[i]) begin : g_unused
            assign set_o[i] = 1'b0;
        end else if (EDGE_SRC[i]) begin : g_fall
            assign set_o[i] = prev_q[i] & ~sync_i[i];
        end else begin : g_level
            assign set_o[i] = ~sync_i[i];
        end
    end

endmodule

// File: rtl/birq_regs.sv
module birq_regs
    import birq_pkg::*;
#(
    parameter int                N_SRC    = 16,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] MASK_OFS = 4'h4,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 4'hC,
    parameter logic [N_SRC-1:0]  USED_SRC = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [N_SRC-1:0]  wdata_i,
    output logic [N_SRC-1:0]  rdata_o,
    input  logic [N_SRC-1:0]  set_i,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0]  flag_o
);

    reg_sel_e         sel;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] keep;
    logic [N_SRC-1:0] flag_nxt;

    always_comb begin
        if (addr_i == MASK_OFS) begin
            sel = SEL_MASK;
        end else if (addr_i == FLAG_OFS) begin
            sel = SEL_FLAG;
        end else begin
            sel = SEL_NONE;
        end
    end

    // A zero in the written word drops the flag; a new request wins.
    always_comb begin
        keep = '1;
        if (wr_i && sel == SEL_FLAG) begin
            keep = wdata_i;
        end
        flag_nxt = ((flag_q & keep) | set_i) & USED_SRC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            flag_q <= '0;
        end else begin
            flag_q <= flag_nxt;
            if (wr_i && sel == SEL_MASK) begin
                mask_q <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (sel)
                SEL_MASK: rdata_o = mask_q;
                SEL_FLAG: rdata_o = flag_q;
                SEL_NONE: rdata_o = '0;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign mask_o = mask_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/birq_route.sv
module birq_route #(
    parameter int                     N_SRC = 16,
    parameter int                     N_OUT = 4,
    parameter logic [N_OUT*N_SRC-1:0] ROUTE = 64'h6386_1C00_0050_0028
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] flag_i,
    input  logic [N_SRC-1:0] mask_i,
    output logic [N_OUT-1:0] irq_o
);

    logic [N_SRC-1:0] live;
    logic [N_OUT-1:0] irq_q;

    assign live = flag_i & ~mask_i;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam logic [N_SRC-1:0] GROUP = ROUTE[k*N_SRC +: N_SRC];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                irq_q[k] <= 1'b0;
            end else begin
                irq_q[k] <= |(live & GROUP);
            end
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/board_irq_cascade.sv
module board_irq_cascade #(
    parameter int                     N_SRC    = 16,
    parameter int                     N_OUT    = 4,
    parameter int                     ADDR_W   = 4,
    parameter logic [ADDR_W-1:0]      MASK_OFS = 4'h4,
    parameter logic [ADDR_W-1:0]      FLAG_OFS = 4'hC,
    parameter logic [N_SRC-1:0]       USED_SRC = 16'hFFFE,
    parameter logic [N_SRC-1:0]       EDGE_SRC = 16'h8000,
    parameter logic [N_OUT*N_SRC-1:0] ROUTE    = 64'h6386_1C00_0050_0028
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_n_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [N_SRC-1:0]  bus_wdata_i,
    output logic [N_SRC-1:0]  bus_rdata_o,
    output logic [N_OUT-1:0]  cpu_irq_o
);

    logic [N_SRC-1:0] sync_q;
    logic [N_SRC-1:0] set_pulse;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] flag_q;

    birq_sync #(.N_SRC(N_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_n_i),
        .sync_o  (sync_q)
    );

    birq_detect #(
        .N_SRC    (N_SRC),
        .USED_SRC (USED_SRC),
        .EDGE_SRC (EDGE_SRC)
    ) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_q),
        .set_o  (set_pulse)
    );

    birq_regs #(
        .N_SRC    (N_SRC),
        .ADDR_W   (ADDR_W),
        .MASK_OFS (MASK_OFS),
        .FLAG_OFS (FLAG_OFS),
        .USED_SRC (USED_SRC)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .wdata_i (bus_wdata_i),
        .rdata_o (bus_rdata_o),
        .set_i   (set_pulse),
        .mask_o  (mask_q),
        .flag_o  (flag_q)
    );

    birq_route #(
        .N_SRC (N_SRC),
        .N_OUT (N_OUT),
        .ROUTE (ROUTE)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_q),
        .mask_i (mask_q),
        .irq_o  (cpu_irq_o)
    );

endmodule

// File: rtl/board_irq_cascade_chk.sv
module board_irq_cascade_chk #(
    parameter int                     N_SRC    = 16,
    parameter int                     N_OUT    = 4,
    parameter int                     ADDR_W   = 4,
    parameter logic [ADDR_W-1:0]      MASK_OFS = 4'h4,
    parameter logic [ADDR_W-1:0]      FLAG_OFS = 4'hC,
    parameter logic [N_SRC-1:0]       USED_SRC = 16'hFFFE,
    parameter logic [N_SRC-1:0]       EDGE_SRC = 16'h8000,
    parameter logic [N_OUT*N_SRC-1:0] ROUTE    = 64'h6386_1C00_0050_0028
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  sync_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  flag_q,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_wr_i,
    input logic              bus_rd_i,
    input logic [N_SRC-1:0]  bus_rdata_o,
    input logic [N_OUT-1:0]  cpu_irq_o
);

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr_i && bus_addr_i == MASK_OFS) |-> $stable(mask_q)); // R2

    AST_UNUSED_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == FLAG_OFS) |-> !bus_rdata_o[0]); // R6

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i != MASK_OFS && bus_addr_i != FLAG_OFS) |-> bus_rdata_o == '0); // R9

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (USED_SRC[i] && !EDGE_SRC[i]) begin : g_lvl
            AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(sync_q[i]) |-> flag_q[i]); // R3
        end
        if (USED_SRC[i] && EDGE_SRC[i]) begin : g_edge
            AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q[i]) |-> (!$past(sync_q[i]) && $past(sync_q[i], 2))); // R5
        end
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam logic [N_SRC-1:0] GROUP = ROUTE[k*N_SRC +: N_SRC];
        AST_OUT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq_o[k] == |($past(flag_q & ~mask_q) & GROUP)); // R7
    end

endmodule

bind board_irq_cascade board_irq_cascade_chk #(
    .N_SRC    (N_SRC),
    .N_OUT    (N_OUT),
    .ADDR_W   (ADDR_W),
    .MASK_OFS (MASK_OFS),
    .FLAG_OFS (FLAG_OFS),
    .USED_SRC (USED_SRC),
    .EDGE_SRC (EDGE_SRC),
    .ROUTE    (ROUTE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_q      (sync_q),
    .mask_q      (mask_q),
    .flag_q      (flag_q),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .cpu_irq_o   (cpu_irq_o)
);

// File: tb/board_irq_cascade_test.sv
`timescale 1ns/1ps
module board_irq_cascade_test;

    localparam logic [3:0] A_MASK = 4'h4;
    localparam logic [3:0] A_FLAG = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_n = 16'hFFFF;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    board_irq_cascade uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_n_i     (src_n),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr_en),
        .bus_rd_i    (rd_en),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .cpu_irq_o   (cpu_irq)
    );

    function automatic logic [3:0] exp_out(logic [15:0] live);
        logic [3:0] r;
        r[0] = (live & 16'h0028) != 0;
        r[1] = (live & 16'h0050) != 0;
        r[2] = (live & 16'h1C00) != 0;
        r[3] = (live & 16'h6386) != 0;
        return r;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(logic [3:0] a, logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [15:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        logic [15:0] m;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset values
        bus_rd(A_MASK, d); chk("R1", "mask after reset", d, 16'hFFFF);
        bus_rd(A_FLAG, d); chk("R1", "flags after reset", d, 16'h0000);
        chk("R1", "outputs after reset", {12'h0, cpu_irq}, 16'h0);

        // R2 mask storage, bit 0 included
        foreach (d[b]) begin
            bus_wr(A_MASK, 16'h1 << b);
            bus_rd(A_MASK, m); chk("R2", "mask one-hot readback", m, 16'h1 << b);
        end
        // R9 unmapped offsets and idle reads
        bus_wr(A_MASK, 16'hA5A5);
        bus_wr(4'h8, 16'h0000);
        bus_wr(4'h0, 16'h0000);
        bus_rd(A_MASK, d); chk("R9", "mask after unmapped writes", d, 16'hA5A5);
        bus_rd(4'h8, d); chk("R9", "unmapped read", d, 16'h0000);
        addr = A_MASK; #1; chk("R9", "read with strobe low", rdata, 16'h0000);
        bus_wr(A_MASK, 16'h0000);

        // R3 timing of a level request
        src_n[3] = 1'b0;
        step(2);
        bus_rd(A_FLAG, d); chk("R3", "flag before third edge", d, 16'h0000);
        step(1);
        bus_rd(A_FLAG, d); chk("R3", "flag at third edge", d, 16'h0008);
        chk("R7", "output not yet", {12'h0, cpu_irq}, 16'h0);
        step(1);
        chk("R7", "output one cycle after flag", {12'h0, cpu_irq}, {12'h0, exp_out(16'h0008)});
        src_n[3] = 1'b1;
        step(3);
        bus_wr(A_FLAG, 16'h0000);

        // R3 R4 R7 sweep over every level source
        for (int i = 1; i <= 14; i++) begin
            src_n[i] = 1'b0;
            step(5);
            bus_rd(A_FLAG, d); chk("R3", "level flag set", d, 16'h1 << i);
            chk("R7", "routed output", {12'h0, cpu_irq}, {12'h0, exp_out(16'h1 << i)});
            bus_wr(A_FLAG, 16'h0000);
            step(2);
            bus_rd(A_FLAG, d); chk("R3", "clear while held low", d, 16'h1 << i);
            src_n[i] = 1'b1;
            step(3);
            bus_wr(A_FLAG, ~(16'h1 << i));
            bus_rd(A_FLAG, d); chk("R4", "clear by zero bit", d, 16'h0000);
            step(1);
            chk("R7", "output drops after clear", {12'h0, cpu_irq}, 16'h0);
        end

        // R4 a one bit keeps its flag
        src_n[2:1] = 2'b00;
        step(4);
        src_n[2:1] = 2'b11;
        step(3);
        bus_wr(A_FLAG, 16'hFFFB);
        bus_rd(A_FLAG, d); chk("R4", "write-one keeps", d, 16'h0002);
        bus_wr(A_FLAG, 16'h0000);

        // R7 R8 mask sweep with all level sources pending
        src_n = 16'h8001;
        step(5);
        for (int j = 0; j < 20; j++) begin
            if (j < 16) m = 16'h1 << j;
            else if (j == 16) m = 16'h0000;
            else if (j == 17) m = 16'hFFFF;
            else if (j == 18) m = 16'h5555;
            else m = 16'hAAAA;
            bus_wr(A_MASK, m);
            step(1);
            chk("R7", "masked routing", {12'h0, cpu_irq}, {12'h0, exp_out(16'h7FFE & ~m)});
            bus_rd(A_FLAG, d); chk("R8", "flags unaffected by mask", d, 16'h7FFE);
        end
        src_n = 16'hFFFF;
        step(3);
        bus_wr(A_FLAG, 16'h0000);
        bus_wr(A_MASK, 16'h0000);

        // R5 falling-edge source
        src_n[15] = 1'b0;
        step(5);
        bus_rd(A_FLAG, d); chk("R5", "edge latched", d, 16'h8000);
        chk("R7", "source 15 in no group", {12'h0, cpu_irq}, 16'h0);
        bus_wr(A_FLAG, 16'h7FFF);
        step(3);
        bus_rd(A_FLAG, d); chk("R5", "held low after clear", d, 16'h0000);
        src_n[15] = 1'b1;
        step(4);
        bus_rd(A_FLAG, d); chk("R5", "rising edge ignored", d, 16'h0000);
        src_n[15] = 1'b0;
        step(5);
        bus_rd(A_FLAG, d); chk("R5", "second press latched", d, 16'h8000);
        src_n[15] = 1'b1;
        step(3);
        bus_wr(A_FLAG, 16'h0000);

        // R6 unused source 0
        src_n[0] = 1'b0;
        step(5);
        bus_rd(A_FLAG, d); chk("R6", "source 0 flag", d, 16'h0000);
        chk("R6", "source 0 outputs", {12'h0, cpu_irq}, 16'h0);
        src_n[0] = 1'b1;
        step(2);

        finish_run();
    end

endmodule